// File: doc/BRIEF.md
# Temperature Alarm Register and Event Logic

This block holds the settings of a temperature monitor and drives one alarm pin. Software reaches it through a small synchronous register port. That port has an address, write data, a write strobe, a read strobe and registered read data. A converter delivers signed 11-bit temperature samples with a valid strobe. The block keeps the latest sample and compares it against three limits: an upper and a lower alarm limit that together form a window, and a critical limit. From that comparison it drives an active-low event pin.

The event works in one of two modes. In comparator mode it follows the present comparison result. In interrupt mode a violation is latched until software clears it. Two sticky lock bits protect the thresholds once the system is set up. One lock guards the critical limit. The other guards the window limits. Either lock also freezes the bits that control the event. The locks fall only on reset.

Top module: `tmon_alarm_top`

## Requirements
- R1: After reset, every configuration bit reads 0 and `event_n` is 1. The upper and critical limits read 0x03FF, the lower limit reads 0xFC00 and the sample reads 0.
- R2: Configuration bit 7 is the critical lock. Writing 1 sets it in a single write. Writing 0 never clears it. While it is set, writes to the critical limit (address 4) are ignored.
- R3: Configuration bit 6 is the window lock. Writing 1 sets it in a single write. Writing 0 never clears it. While it is set, writes to the upper limit (address 2) and the lower limit (address 3) are ignored.
- R4: While either lock is set, the enable bit (bit 3) and the critical-only bit (bit 2) keep their values. The mode bit (bit 0) stays writable.
- R5: Configuration bit 5 always reads 0. Writing it as 1 clears a latched event when the mode held before that write is interrupt. In comparator mode it has no effect.
- R6: Configuration bit 4 reads the internal event state before the enable gate. Writes to bit 4 are ignored. Bit 1 reads 0.
- R7: `event_n` is low exactly when the event state is 1 and the enable bit (bit 3) is 1.
- R8: All comparisons are signed 11-bit two's-complement. A window violation means the sample is greater than the upper limit or less than the lower limit. A critical violation means the sample is greater than or equal to the critical limit.
- R9: When bit 2 is 1, only a critical violation counts. When bit 2 is 0, either kind of violation counts.
- R10: When bit 0 is 0 (comparator mode), the event state equals the violation result for the stored sample and the current limits.
- R11: When bit 0 is 1 (interrupt mode), a violation is latched on the cycle after a sample is captured. The latch holds until a clear. A violation latched in the same cycle as a clear wins over the clear. Switching to comparator mode empties the latch.
- R12: The register map is: 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit, 5 last sample (read-only). Limits and the sample read back sign-extended to 16 bits. Other addresses read 0. Read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| temp_in | input | 11 | Signed temperature sample |
| temp_valid | input | 1 | Sample valid strobe |
| event_n | output | 1 | Active-low event pin |

## Verification
In interrupt mode, a software clear of the latched event can land in the same cycle in which a newly captured sample would latch a violation. The bench forces this coincidence directly. It drives a violating sample and then issues the clear write exactly one cycle later, so that the clear meets the latch update. It then reads the status bit and the pin, expecting the event to remain set. It repeats the same timing with a benign sample and expects the clear to take effect.

// File: rtl/tmon_pkg.sv
// Package: register addresses and configuration bit positions shared by
// the temperature alarm block. Assumes an address port of at least 3 bits.
package tmon_pkg;
    localparam int ADR_CFG   = 1;
    localparam int ADR_UPPER = 2;
    localparam int ADR_LOWER = 3;
    localparam int ADR_CRIT  = 4;
    localparam int ADR_TEMP  = 5;

    localparam int B_LOCK_C  = 7;
    localparam int B_LOCK_W  = 6;
    localparam int B_CLR     = 5;
    localparam int B_STAT    = 4;
    localparam int B_EN      = 3;
    localparam int B_CRITONLY = 2;
    localparam int B_MODE    = 0;

    typedef enum logic {MODE_CMP = 1'b0, MODE_INT = 1'b1} evt_mode_e;
endpackage

// File: rtl/tmon_regs.sv
// Module: writable registers of the alarm block (locks, control bits and
// the three limits). Assumes writes are single-cycle strobes; the lock
// state used to gate a write is the state held before that write.
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     wr_en,
    output logic signed [TEMP_W-1:0] upper_q,
    output logic signed [TEMP_W-1:0] lower_q,
    output logic signed [TEMP_W-1:0] crit_q,
    output logic                     lock_c_q,
    output logic                     lock_w_q,
    output logic                     en_q,
    output logic                     critonly_q,
    output evt_mode_e                mode_q,
    output logic                     clr_req
);
    localparam logic [TEMP_W-1:0] POS_MAX = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [TEMP_W-1:0] NEG_MIN = {1'b1, {(TEMP_W-1){1'b0}}};

    logic wr_cfg, wr_up, wr_lo, wr_cr, any_lock;

    // Decode write strobes per register.
    always_comb begin
        wr_cfg   = wr_en && (addr == ADDR_W'(ADR_CFG));
        wr_up    = wr_en && (addr == ADDR_W'(ADR_UPPER));
        wr_lo    = wr_en && (addr == ADDR_W'(ADR_LOWER));
        wr_cr    = wr_en && (addr == ADDR_W'(ADR_CRIT));
        any_lock = lock_c_q || lock_w_q;
        clr_req  = wr_cfg && wdata[B_CLR];
    end

    // Configuration: sticky locks, lock-guarded control bits, free mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_c_q   <= 1'b0;
            lock_w_q   <= 1'b0;
            en_q       <= 1'b0;
            critonly_q <= 1'b0;
            mode_q     <= MODE_CMP;
        end else if (wr_cfg) begin
            lock_c_q <= lock_c_q | wdata[B_LOCK_C];
            lock_w_q <= lock_w_q | wdata[B_LOCK_W];
            if (!any_lock) begin
                en_q       <= wdata[B_EN];
                critonly_q <= wdata[B_CRITONLY];
            end
            mode_q <= evt_mode_e'(wdata[B_MODE]);
        end
    end

    // Limit registers, each frozen by its own lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= POS_MAX;
            lower_q <= NEG_MIN;
            crit_q  <= POS_MAX;
        end else begin
            if (wr_up && !lock_w_q) upper_q <= wdata[TEMP_W-1:0];
            if (wr_lo && !lock_w_q) lower_q <= wdata[TEMP_W-1:0];
            if (wr_cr && !lock_c_q) crit_q  <= wdata[TEMP_W-1:0];
        end
    end

    p_crit_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_c_q && wr_cr) |=> $stable(crit_q));
    p_win_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w_q && (wr_up || wr_lo)) |=> ($stable(upper_q) && $stable(lower_q)));
    p_ctl_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_c_q || lock_w_q) |=> ($stable(en_q) && $stable(critonly_q)));
endmodule

// File: rtl/tmon_compare.sv
// Module: captures each valid sample and compares the stored sample with
// the window and critical limits in signed arithmetic. The fresh flag
// marks the cycle right after a capture.
module tmon_compare #(
    parameter int TEMP_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_in,
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] upper,
    input  logic signed [TEMP_W-1:0] lower,
    input  logic signed [TEMP_W-1:0] crit,
    input  logic                     critonly,
    output logic signed [TEMP_W-1:0] sample_q,
    output logic                     fresh_q,
    output logic                     viol
);
    logic win_hit, crit_hit;

    // Hold the last sample and flag its arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            fresh_q  <= 1'b0;
        end else begin
            fresh_q <= temp_valid;
            if (temp_valid) sample_q <= temp_in;
        end
    end

    // Signed comparisons against the limits, then the critical-only filter.
    always_comb begin
        win_hit  = (sample_q > upper) || (sample_q < lower);
        crit_hit = (sample_q >= crit);
        viol     = critonly ? crit_hit : (win_hit || crit_hit);
    end

    p_sample_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |=> (sample_q == $past(temp_in)));
endmodule

// File: rtl/tmon_event.sv
// Module: event state. Comparator mode follows the violation; interrupt
// mode latches it on a fresh sample and drops it on a clear request,
// with a same-cycle new violation taking priority over the clear.
module tmon_event
    import tmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  evt_mode_e mode,
    input  logic      clr_req,
    input  logic      fresh,
    input  logic      viol,
    output logic      state
);
    logic latch_q;

    // Interrupt latch; emptied whenever comparator mode is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                latch_q <= 1'b0;
        else if (mode == MODE_CMP) latch_q <= 1'b0;
        else                       latch_q <= (latch_q && !clr_req) || (fresh && viol);
    end

    // Select the event state by mode.
    always_comb state = (mode == MODE_INT) ? latch_q : viol;

    p_int_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INT && latch_q && !clr_req) |=> (latch_q || mode == MODE_CMP || $past(mode) == MODE_CMP) || latch_q);
    p_int_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INT && fresh && viol) |=> latch_q);
endmodule

// File: rtl/tmon_alarm_top.sv
// Module: top of the temperature alarm block. Ties the register file,
// comparator and event logic together, drives the active-low pin and
// returns registered read data one cycle after a read strobe.
module tmon_alarm_top
    import tmon_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rdata,
    input  logic signed [TEMP_W-1:0] temp_in,
    input  logic                     temp_valid,
    output logic                     event_n
);
    localparam int EXT_W = DATA_W - TEMP_W;

    logic signed [TEMP_W-1:0] upper, lower, crit, sample;
    logic lock_c, lock_w, en, critonly, clr_req, fresh, viol, state;
    evt_mode_e mode;
    logic [DATA_W-1:0] cfg_word, rd_mux;

    tmon_regs #(.TEMP_W(TEMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .upper_q(upper), .lower_q(lower), .crit_q(crit),
        .lock_c_q(lock_c), .lock_w_q(lock_w), .en_q(en),
        .critonly_q(critonly), .mode_q(mode), .clr_req(clr_req)
    );

    tmon_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .temp_valid(temp_valid),
        .upper(upper), .lower(lower), .crit(crit), .critonly(critonly),
        .sample_q(sample), .fresh_q(fresh), .viol(viol)
    );

    tmon_event u_evt (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clr_req(clr_req),
        .fresh(fresh), .viol(viol), .state(state)
    );

    // Assemble the configuration word; clear and spare bits read 0.
    always_comb begin
        cfg_word             = '0;
        cfg_word[B_LOCK_C]   = lock_c;
        cfg_word[B_LOCK_W]   = lock_w;
        cfg_word[B_STAT]     = state;
        cfg_word[B_EN]       = en;
        cfg_word[B_CRITONLY] = critonly;
        cfg_word[B_MODE]     = mode;
    end

    // Read multiplexer with sign extension of limits and sample.
    always_comb begin
        unique case (int'(addr))
            ADR_CFG:   rd_mux = cfg_word;
            ADR_UPPER: rd_mux = {{EXT_W{upper[TEMP_W-1]}}, upper};
            ADR_LOWER: rd_mux = {{EXT_W{lower[TEMP_W-1]}}, lower};
            ADR_CRIT:  rd_mux = {{EXT_W{crit[TEMP_W-1]}}, crit};
            ADR_TEMP:  rd_mux = {{EXT_W{sample[TEMP_W-1]}}, sample};
            default:   rd_mux = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // Active-low pin gated by the enable bit.
    always_comb event_n = !(state && en);

    p_cfg_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_CFG)) |=> (rdata[B_CLR] == 1'b0 && rdata[1] == 1'b0));
    p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> event_n);
    p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == '0 || addr > ADDR_W'(ADR_TEMP))) |=> (rdata == '0));
endmodule

// File: tb/sim_tmon_alarm_top.sv
module sim_tmon_alarm_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 1234;

    logic clk = 0, rst_n = 0;
    logic [2:0] addr = '0;
    logic [15:0] wdata = '0;
    logic wr_en = 0, rd_en = 0, temp_valid = 0;
    logic signed [10:0] temp_in = '0;
    logic [15:0] rdata;
    logic event_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic signed [10:0] m_up, m_lo, m_cr, m_samp;
    logic m_lc, m_lw, m_en, m_co, m_mode, m_latch;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmon_alarm_top u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .temp_in(temp_in),
        .temp_valid(temp_valid), .event_n(event_n));

    function automatic logic f_viol(logic signed [10:0] t);
        logic w, c;
        w = (t > m_up) || (t < m_lo);
        c = (t >= m_cr);
        return m_co ? c : (w || c);
    endfunction

    function automatic logic f_state();
        return m_mode ? m_latch : f_viol(m_samp);
    endfunction

    function automatic logic [15:0] f_cfg();
        return {8'h00, m_lc, m_lw, 1'b0, f_state(), m_en, m_co, 1'b0, m_mode};
    endfunction

    function automatic logic [15:0] f_sx(logic signed [10:0] v);
        return {{5{v[10]}}, v};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [15:0] d);
        logic old_lock;
        @(negedge clk); addr = 3'(a); wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        case (a)
            1: begin
                old_lock = m_lc | m_lw;
                if (m_mode && d[5]) m_latch = 0;
                m_lc = m_lc | d[7];
                m_lw = m_lw | d[6];
                if (!old_lock) begin m_en = d[3]; m_co = d[2]; end
                m_mode = d[0];
                if (!m_mode) m_latch = 0;
            end
            2: if (!m_lw) m_up = d[10:0];
            3: if (!m_lw) m_lo = d[10:0];
            4: if (!m_lc) m_cr = d[10:0];
            default: ;
        endcase
    endtask

    task automatic reg_read(input int a, output logic [15:0] d);
        @(negedge clk); addr = 3'(a); rd_en = 1;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic put_temp(input logic signed [10:0] t);
        @(negedge clk); temp_in = t; temp_valid = 1;
        @(negedge clk); temp_valid = 0;
        @(negedge clk);
        m_samp = t;
        if (m_mode && f_viol(t)) m_latch = 1;
    endtask

    task automatic check_all(input string tag);
        logic [15:0] d;
        check({tag, " R7 event_n"}, {15'd0, event_n}, {15'd0, !(f_state() && m_en)});
        reg_read(1, d); check({tag, " R6 cfg"}, d, f_cfg());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int seed_dummy;
        seed_dummy = $urandom(SEED);
        m_up = 11'sh3FF; m_lo = -11'sd1024; m_cr = 11'sh3FF; m_samp = 0;
        m_lc = 0; m_lw = 0; m_en = 0; m_co = 0; m_mode = 0; m_latch = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 event_n", {15'd0, event_n}, 16'd1);
        reg_read(1, d); check("R1 cfg", d, 16'h0000);
        reg_read(2, d); check("R1 upper", d, 16'h03FF);
        reg_read(3, d); check("R1 lower", d, 16'hFC00);
        reg_read(4, d); check("R1 crit", d, 16'h03FF);
        reg_read(5, d); check("R1 sample", d, 16'h0000);

        // R12 map, unused addresses, sample read-only
        reg_read(0, d); check("R12 addr0", d, 16'h0);
        reg_read(6, d); check("R12 addr6", d, 16'h0);
        reg_read(7, d); check("R12 addr7", d, 16'h0);
        reg_write(5, 16'h0123);
        reg_read(5, d); check("R12 sample ro", d, 16'h0000);

        // R8 boundaries, comparator mode, enabled
        reg_write(2, 16'd100); reg_write(3, 16'hFFF6); reg_write(4, 16'd200);
        reg_write(1, 16'h0008);
        put_temp(11'sd100); check_all("R8 at upper");
        put_temp(11'sd101); check_all("R8 above upper");
        put_temp(-11'sd10); check_all("R8 at lower");
        put_temp(-11'sd11); check_all("R8 below lower");
        put_temp(11'sd200); check_all("R8 at crit");
        reg_read(5, d); check("R12 sample sx", d, 16'h00C8);
        put_temp(-11'sd300); reg_read(5, d); check("R12 neg sx", d, f_sx(-11'sd300));
        // R9 critical-only
        reg_write(1, 16'h000C);
        put_temp(11'sd150); check_all("R9 window only");
        put_temp(11'sd250); check_all("R9 crit");
        // R10 comparator follows limit change
        reg_write(4, 16'd300); check_all("R10 follow");
        // R6 status before gate
        reg_write(1, 16'h0014); put_temp(11'sd400); check_all("R6 status no en");

        // R11 interrupt latch and R5 clear
        reg_write(1, 16'h0009);
        put_temp(11'sd400); check_all("R11 latched");
        put_temp(11'sd0); check_all("R11 held");
        reg_write(1, 16'h0029); check_all("R5 cleared");
        // R11 same-cycle: violation captured, clear lands on latch-update cycle
        put_temp(11'sd400);
        reg_write(1, 16'h0029); check_all("R5 clear");
        @(negedge clk); temp_in = 11'sd400; temp_valid = 1;
        @(negedge clk); temp_valid = 0; addr = 3'd1; wdata = 16'h0029; wr_en = 1;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        m_samp = 11'sd400; m_latch = 1;
        check_all("R11 set beats clear");
        @(negedge clk); temp_in = 11'sd0; temp_valid = 1;
        @(negedge clk); temp_valid = 0; addr = 3'd1; wdata = 16'h0029; wr_en = 1;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        m_samp = 11'sd0; m_latch = 0;
        check_all("R11 clear benign");
        // R5 clear in comparator mode has no effect
        reg_write(1, 16'h0008); put_temp(11'sd400);
        reg_write(1, 16'h0028); check_all("R5 cmp no effect");
        // R6 write to status bit ignored
        reg_write(1, 16'h0010); put_temp(11'sd0); check_all("R6 status ro");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 5;
            case (op)
                0: reg_write(2 + ($urandom % 3), 16'($urandom % 2048));
                1: reg_write(1, 16'($urandom) & 16'h003D);
                2, 3: put_temp(11'($urandom % 2048));
                default: begin
                    int a;
                    a = $urandom % 8;
                    reg_read(a, d);
                    case (a)
                        1: check("R12 rand cfg", d, f_cfg());
                        2: check("R12 rand up", d, f_sx(m_up));
                        3: check("R12 rand lo", d, f_sx(m_lo));
                        4: check("R12 rand cr", d, f_sx(m_cr));
                        5: check("R12 rand samp", d, f_sx(m_samp));
                        default: check("R12 rand unused", d, 16'h0);
                    endcase
                end
            endcase
            check("R10 R11 rand pin", {15'd0, event_n}, {15'd0, !(f_state() && m_en)});
        end

        // R2 critical lock
        reg_write(1, 16'h0008);
        reg_write(4, 16'd50);
        reg_write(1, 16'h0088);
        reg_write(4, 16'd77); reg_read(4, d); check("R2 crit frozen", d, 16'd50);
        reg_write(2, 16'd60); reg_read(2, d); check("R2 upper free", d, 16'd60);
        reg_write(1, 16'h0000); reg_read(1, d); check("R2 R4 lock sticky", d, f_cfg());
        check("R4 en kept", {15'd0, d[3]}, 16'd1);
        reg_write(1, 16'h0001); reg_read(1, d); check("R4 mode free", {15'd0, d[0]}, 16'd1);
        // R3 window lock
        reg_write(1, 16'h0040);
        reg_write(2, 16'd5); reg_read(2, d); check("R3 upper frozen", d, 16'd60);
        reg_write(3, 16'd5); reg_read(3, d); check("R3 lower frozen", d, f_sx(m_lo));
        reg_read(1, d); check("R3 both locks", d, f_cfg());

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule